// File: doc/BRIEF.md
# Filter Accumulator With Output Register

This block is the summing stage at the end of a tap-by-tap filter datapath. Each clock it receives one signed term, a product or partial sum, together with one accumulate-control bit. Both are captured on the rising clock edge. On the next edge the captured control decides what the datapath does.

With the captured control high, the block is in the summing phase. The new term is added into the running total and the output register keeps its value. With the captured control low, the block is in the load phase. The running total restarts from the new term, and the output register takes the total that was just completed.

A filter sequencer therefore marks the first term of each group with the control low and the remaining terms with it high. Each completed sum then appears at `dout` and stays there while the next group builds.

The captured control is held as a two-state phase register:
- `PH_LOAD` is the restart/load phase.
- `PH_SUM` is the summing phase.

Its four transitions are named:
- LOAD→LOAD is a single-term group.
- LOAD→SUM opens a multi-term group.
- SUM→SUM continues a group.
- SUM→LOAD closes a group.

The accumulator carries `clog2(MAX_TAPS)` guard bits above the input width.

Top module: `filt_accum`

## Requirements
- R1: In a cycle where the captured control is high (`PH_SUM`), the running total becomes its previous value plus the captured term, sign-extended.
- R2: In a cycle where the captured control is high, `dout` keeps its previous value.
- R3: In a cycle where the captured control is low (`PH_LOAD`), the running total becomes the captured term alone. No earlier total contributes to the next group.
- R4: In a cycle where the captured control is low, `dout` loads the running total as it stood before that restart.
- R5: `acc_ctl` and `din` are captured on the same rising edge. A group closed by a low-control sample at edge E shows its sum at `dout` after edge E+1. After edge E alone, `dout` still shows the older value.
- R6: The accumulator and `dout` are `DIN_W + clog2(MAX_TAPS)` bits wide, two's complement. A group of up to `MAX_TAPS` terms, including all terms at the most negative or most positive input, sums exactly.
- R7: A synchronous reset clears the running total, `dout` and the captured control (to `PH_LOAD`), whatever `acc_ctl` is at the time.
- R8: With `acc_ctl` held low every cycle, every term is a one-term group. The term sampled at edge E appears at `dout` after edge E+2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| acc_ctl | input | 1 | 1 = add this term to the group, 0 = start a new group with this term |
| din | input | DIN_W | Signed input term |
| dout | output | DIN_W+clog2(MAX_TAPS) | Signed total of the last completed group |

## Verification
The hardest case to reach is the pipeline skew: the output register loads one edge after the closing sample, not on it. From the ports that looks like a stale value, so it is easy to miss. Each directed group ends with a low-control filler term. The bench checks that `dout` still shows the previous group's total after that edge, and only then expects the new sum. The arithmetic limit is reached by feeding `MAX_TAPS` copies of the most negative term and then of the most positive term, which fills every guard bit.

// File: rtl/fac_pkg.sv
package fac_pkg;

    typedef enum logic {
        PH_LOAD = 1'b0,
        PH_SUM  = 1'b1
    } phase_e;

endpackage

// File: rtl/fac_ctl_fsm.sv
module fac_ctl_fsm
    import fac_pkg::*;
#(
    parameter int DIN_W = 12
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    acc_ctl,
    input  logic signed [DIN_W-1:0] din,
    output phase_e                  ph_q,
    output logic signed [DIN_W-1:0] din_q
);

    phase_e ph_d;

    // Next phase follows the sampled control.
    always_comb begin
        ph_d = ph_q;
        unique case (ph_q)
            PH_LOAD: ph_d = acc_ctl ? PH_SUM : PH_LOAD;
            PH_SUM:  ph_d = acc_ctl ? PH_SUM : PH_LOAD;
        endcase
    end

    // Phase register.
    always_ff @(posedge clk) begin
        if (rst) ph_q <= PH_LOAD;
        else     ph_q <= ph_d;
    end

    // Term captured on the same edge as the control.
    always_ff @(posedge clk) begin
        if (rst) din_q <= '0;
        else     din_q <= din;
    end

endmodule

// File: rtl/fac_sum.sv
module fac_sum
    import fac_pkg::*;
#(
    parameter int DIN_W = 12,
    parameter int ACC_W = 16
) (
    input  logic                    clk,
    input  logic                    rst,
    input  phase_e                  ph_q,
    input  logic signed [DIN_W-1:0] din_q,
    output logic signed [ACC_W-1:0] acc_q
);

    localparam int EXT_W = ACC_W - DIN_W;

    logic signed [ACC_W-1:0] term_ext;
    logic signed [ACC_W-1:0] acc_d;

    generate
        if (EXT_W > 0) begin : g_ext
            assign term_ext = {{EXT_W{din_q[DIN_W-1]}}, din_q};
        end else begin : g_same
            assign term_ext = din_q;
        end
    endgenerate

    always_comb begin
        acc_d = acc_q;
        unique case (ph_q)
            PH_SUM:  acc_d = acc_q + term_ext;
            PH_LOAD: acc_d = term_ext;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) acc_q <= '0;
        else     acc_q <= acc_d;
    end

endmodule

// File: rtl/fac_out.sv
module fac_out
    import fac_pkg::*;
#(
    parameter int ACC_W = 16
) (
    input  logic                    clk,
    input  logic                    rst,
    input  phase_e                  ph_q,
    input  logic signed [ACC_W-1:0] acc_q,
    output logic signed [ACC_W-1:0] dout
);

    // Completed total is taken only in the load phase.
    always_ff @(posedge clk) begin
        if (rst) begin
            dout <= '0;
        end else begin
            unique case (ph_q)
                PH_LOAD: dout <= acc_q;
                PH_SUM:  dout <= dout;
            endcase
        end
    end

endmodule

// File: rtl/filt_accum.sv
module filt_accum
    import fac_pkg::*;
#(
    parameter  int DIN_W    = 12,
    parameter  int MAX_TAPS = 16,
    localparam int ACC_W    = DIN_W + $clog2(MAX_TAPS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             acc_ctl,
    input  logic [DIN_W-1:0] din,
    output logic [ACC_W-1:0] dout
);

    phase_e                  ph_q;
    logic signed [DIN_W-1:0] din_q;
    logic signed [ACC_W-1:0] acc_q;
    logic signed [ACC_W-1:0] dout_s;

    fac_ctl_fsm #(.DIN_W(DIN_W)) ctl_i (
        .clk     (clk),
        .rst     (rst),
        .acc_ctl (acc_ctl),
        .din     (din),
        .ph_q    (ph_q),
        .din_q   (din_q)
    );

    fac_sum #(.DIN_W(DIN_W), .ACC_W(ACC_W)) sum_i (
        .clk   (clk),
        .rst   (rst),
        .ph_q  (ph_q),
        .din_q (din_q),
        .acc_q (acc_q)
    );

    fac_out #(.ACC_W(ACC_W)) out_i (
        .clk   (clk),
        .rst   (rst),
        .ph_q  (ph_q),
        .acc_q (acc_q),
        .dout  (dout_s)
    );

    assign dout = dout_s;

endmodule

// File: rtl/filt_accum_chk.sv
module filt_accum_chk #(
    parameter int DIN_W = 12,
    parameter int ACC_W = 16
) (
    input logic             clk,
    input logic             rst,
    input logic             acc_ctl,
    input logic [DIN_W-1:0] din,
    input logic             ph,
    input logic [DIN_W-1:0] din_q,
    input logic [ACC_W-1:0] acc_q,
    input logic [ACC_W-1:0] dout
);

    logic signed [ACC_W-1:0] dq_ext;
    assign dq_ext = ACC_W'($signed(din_q));

    a_r1_sum: assert property (@(posedge clk) disable iff (rst)
        ph |=> acc_q == $past(acc_q) + $past(dq_ext));

    a_r2_hold: assert property (@(posedge clk) disable iff (rst)
        ph |=> $stable(dout));

    a_r3_restart: assert property (@(posedge clk) disable iff (rst)
        !ph |=> acc_q == $past(dq_ext));

    a_r4_load: assert property (@(posedge clk) disable iff (rst)
        !ph |=> dout == $past(acc_q));

    a_r5_capture: assert property (@(posedge clk) disable iff (rst)
        !rst |=> (ph == $past(acc_ctl)) && (din_q == $past(din)));

    a_r7_reset: assert property (@(posedge clk)
        rst |=> (dout == '0) && (acc_q == '0) && !ph);

endmodule

bind filt_accum filt_accum_chk #(.DIN_W(DIN_W), .ACC_W(ACC_W)) chk_i (
    .clk     (clk),
    .rst     (rst),
    .acc_ctl (acc_ctl),
    .din     (din),
    .ph      (ph_q),
    .din_q   (din_q),
    .acc_q   (acc_q),
    .dout    (dout)
);

// File: tb/filt_accum_tb_top.sv
`timescale 1ns/1ps
module filt_accum_tb_top;

    localparam int DIN_W    = 12;
    localparam int MAX_TAPS = 16;
    localparam int ACC_W    = DIN_W + $clog2(MAX_TAPS);
    localparam int DMIN     = -(1 << (DIN_W - 1));
    localparam int DMAX     = (1 << (DIN_W - 1)) - 1;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             acc_ctl = 1'b0;
    logic [DIN_W-1:0] din = '0;
    logic [ACC_W-1:0] dout;

    int n_chk = 0;
    int n_bad = 0;
    int pend  = 0;   // total the next group's start will bring to dout

    always #2.5 clk = ~clk;

    filt_accum #(.DIN_W(DIN_W), .MAX_TAPS(MAX_TAPS)) dut_i (
        .clk     (clk),
        .rst     (rst),
        .acc_ctl (acc_ctl),
        .din     (din),
        .dout    (dout)
    );

    function automatic int dout_i();
        return int'($signed(dout));
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Drive one term; returns at the falling edge after the sampling edge.
    task automatic step(input logic c, input int v);
        acc_ctl = c;
        din     = DIN_W'(v);
        @(negedge clk);
    endtask

    task automatic t_reset();
        rst = 1'b1;
        step(1'b1, 55);
        step(1'b1, 66);
        chk("R7 reset clears dout", dout_i(), 0);
        rst = 1'b0;
        pend = 0;
    endtask

    // One group of n terms v0 + k*dv, then two zero single-term groups.
    task automatic run_group(input int n, input int v0, input int dv, input string tag);
        int sum = 0;
        for (int k = 0; k < n; k++) begin
            step(k != 0, v0 + k * dv);
            sum += v0 + k * dv;
            if (k >= 1) chk({tag, " R2 dout holds while summing"}, dout_i(), pend);
        end
        step(1'b0, 0);
        chk({tag, " R5 sum not yet at dout one edge after close"}, dout_i(), pend);
        step(1'b0, 0);
        chk({tag, " R1 R3 R4 group total at dout"}, dout_i(), sum);
        pend = 0;
    endtask

    task automatic t_single_stream();
        int vals[5] = '{13, -7, 400, DMIN, DMAX};
        for (int k = 0; k < 5; k++) begin
            step(1'b0, vals[k]);
            if (k >= 2) chk("R8 one-term groups delayed two edges", dout_i(), vals[k-2]);
        end
        step(1'b0, 0);
        chk("R8 one-term groups delayed two edges", dout_i(), vals[3]);
        step(1'b0, 0);
        chk("R8 one-term groups delayed two edges", dout_i(), vals[4]);
        pend = 0;
    endtask

    task automatic t_reset_mid();
        step(1'b0, 5);
        step(1'b1, 6);
        step(1'b1, 7);
        rst = 1'b1;
        step(1'b1, 100);
        chk("R7 reset mid-group clears dout", dout_i(), 0);
        rst = 1'b0;
        pend = 0;
        run_group(3, 10, 1, "R7 post-reset");
    endtask

    initial begin
        #(200000 * 5);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual hung expected done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        @(negedge clk);
        t_reset();
        run_group(4, 100, 25, "A");
        run_group(3, -300, 250, "B");
        run_group(1, 77, 0, "C");
        run_group(MAX_TAPS, DMIN, 0, "R6 most negative");
        run_group(MAX_TAPS, DMAX, 0, "R6 most positive");
        t_single_stream();
        t_reset_mid();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule